// File: doc/BRIEF.md
# Dual-Rate Hysteretic Gain Regulator

This block keeps the combined amplitude of a quadrature signal pair (a sine channel and a cosine channel) close to a programmed target. It does this by adjusting one gain code that drives both channels, so the two channels always receive the same gain. Each time a new pair of signed peak amplitudes is presented with a valid strobe, the block forms the squared vector magnitude, the sine amplitude squared plus the cosine amplitude squared. It places that value in one of several bands around the target. Comparing squares against squared thresholds gives the same ordering as comparing the root against plain thresholds, so no square root is needed.

Outside the outer thresholds the loop is in the fast band and moves the code by several steps per interval. Between an inner and an outer threshold it is in the slow band and moves one step per interval. Inside the inner thresholds the code is held, which gives the loop hysteresis. Once a correction has started, it continues through the hold zone until the magnitude reaches the target. A settle input selects a short-interval schedule for power-up acquisition. When it is low, the block uses the long-interval tracking schedule. Each code step stands for a fixed ratio of about 0.15 dB in the analog gain stage.

Top module: `agc_dual_rate_ctrl`

## Requirements
- R1: After a synchronous reset the gain code equals the parameter GAIN_INIT (default 64), and one 7-bit code serves both channels.
- R2: Amplitudes are signed 16-bit values. The regulated quantity is sin² + cos² as a 33-bit unsigned value, compared against squared thresholds, so a pair whose components each sit in the slow band can together reach the fast band.
- R3: A magnitude strictly above the fast-high threshold lowers the code, and one strictly below the fast-low threshold raises it. In tracking mode this happens by 4 codes once per fast interval (FAST_NS).
- R4: A magnitude strictly above slow-high (but not above fast-high) lowers the code, and one strictly below slow-low (but not below fast-low) raises it. In tracking mode this happens by 1 code once per slow interval (SLOW_NS).
- R5: With settle_mode = 1, every active band uses the settle interval (SETTLE_NS). The step is 8 codes in the fast band and 1 code in the slow band.
- R6: While no correction is active, a magnitude between slow-low and slow-high inclusive leaves the code unchanged.
- R7: A correction in progress continues at the slow step and rate while the magnitude is inside the hold zone. A downward correction ends when magnitude ≤ target, and an upward one ends when magnitude ≥ target (equality ends it).
- R8: The code saturates at 0 and 127. A multi-code step that would pass a limit lands exactly on the limit.
- R9: When a valid sample changes the active band, the first step comes L+1 clocks after that sample's edge and later steps come every L clocks, where L is the band's interval in clocks. When settle_mode changes, the interval counter restarts and the first step comes L clocks later.
- R10: Amplitude inputs are ignored while sample_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Amplitude pair is valid this cycle |
| sin_amp | input | 16 | Signed peak amplitude, sine channel |
| cos_amp | input | 16 | Signed peak amplitude, cosine channel |
| settle_mode | input | 1 | 1 = initial settling schedule, 0 = tracking schedule |
| fast_hi_sq | input | 33 | Squared fast-high threshold |
| slow_hi_sq | input | 33 | Squared slow-high threshold |
| target_sq | input | 33 | Squared regulation target |
| slow_lo_sq | input | 33 | Squared slow-low threshold |
| fast_lo_sq | input | 33 | Squared fast-low threshold |
| gain_code | output | 7 | Shared gain code for both channels |

## Verification
The bench drives amplitude pairs placed in every band on both sides of the target. One of these pairs has components that each fall in the slow band while their vector sum falls in the fast band, which separates a true sum of squares from a per-channel comparison. Negative amplitudes confirm that the squaring handles sign. Follow-up samples land inside the hold zone on the near and far side of the target, and exactly on it, to separate continued correction from stopping. Further checks taken one clock before and one clock after the predicted step edges, and after a schedule switch partway through an interval, pin down the interval timing. Long runs in settle mode drive the code into both saturation limits through partial steps.

// File: rtl/agc_pkg.sv
package agc_pkg;

    localparam int AMP_W    = 16;
    localparam int MAG_W    = 2 * AMP_W + 1;
    localparam int GAIN_W   = 7;
    localparam int GAIN_MAX = (1 << GAIN_W) - 1;
    localparam int STEP_W   = 4;

    localparam int STEP_FAST_TRACK  = 4;
    localparam int STEP_FAST_SETTLE = 8;
    localparam int STEP_SLOW        = 1;

    typedef logic signed [AMP_W-1:0] amp_t;
    typedef logic [MAG_W-1:0]        mag_t;
    typedef logic [GAIN_W-1:0]       gain_t;
    typedef logic [STEP_W-1:0]       step_t;

    typedef enum logic [1:0] {
        RATE_NONE = 2'd0,
        RATE_SLOW = 2'd1,
        RATE_FAST = 2'd2
    } rate_t;

    // Current correction: band rate and direction (down = lower the code)
    typedef struct packed {
        rate_t rate;
        logic  down;
    } corr_t;

    typedef struct packed {
        mag_t fast_hi;
        mag_t slow_hi;
        mag_t target;
        mag_t slow_lo;
        mag_t fast_lo;
    } bands_t;

    function automatic mag_t square_mag(amp_t a);
        logic signed [2*AMP_W-1:0] prod;
        prod = a * a;
        return MAG_W'(unsigned'(prod));
    endfunction

    function automatic step_t step_codes(logic settle, rate_t r);
        case (r)
            RATE_FAST: return settle ? step_t'(STEP_FAST_SETTLE) : step_t'(STEP_FAST_TRACK);
            RATE_SLOW: return step_t'(STEP_SLOW);
            default:   return '0;
        endcase
    endfunction

    function automatic gain_t apply_step(gain_t g, step_t s, logic down);
        int res;
        res = down ? int'(g) - int'(s) : int'(g) + int'(s);
        if (res < 0)        res = 0;
        if (res > GAIN_MAX) res = GAIN_MAX;
        return gain_t'(res);
    endfunction

    function automatic longint ns_to_cycles(longint khz, longint ns);
        longint c;
        c = (khz * ns) / 64'd1000000;
        return (c < 1) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/agc_vector_mag.sv
module agc_vector_mag
    import agc_pkg::*;
(
    input  amp_t sin_amp,
    input  amp_t cos_amp,
    output mag_t mag_sq
);
    mag_t sin_sq;
    mag_t cos_sq;

    assign sin_sq = square_mag(sin_amp);
    assign cos_sq = square_mag(cos_amp);
    assign mag_sq = sin_sq + cos_sq;
endmodule

// File: rtl/agc_band_classifier.sv
module agc_band_classifier
    import agc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sample_valid,
    input  mag_t   mag_sq,
    input  bands_t bands,
    output corr_t  corr_q
);
    corr_t corr_d;
    logic  reached;

    always_comb begin
        reached = corr_q.down ? (mag_sq <= bands.target) : (mag_sq >= bands.target);
        if (mag_sq > bands.fast_hi) begin
            corr_d = '{rate: RATE_FAST, down: 1'b1};
        end else if (mag_sq < bands.fast_lo) begin
            corr_d = '{rate: RATE_FAST, down: 1'b0};
        end else if (mag_sq > bands.slow_hi) begin
            corr_d = '{rate: RATE_SLOW, down: 1'b1};
        end else if (mag_sq < bands.slow_lo) begin
            corr_d = '{rate: RATE_SLOW, down: 1'b0};
        end else if (corr_q.rate != RATE_NONE && !reached) begin
            corr_d = '{rate: RATE_SLOW, down: corr_q.down};
        end else begin
            corr_d = '{rate: RATE_NONE, down: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_q <= '{rate: RATE_NONE, down: 1'b0};
        end else if (sample_valid) begin
            corr_q <= corr_d;
        end
    end

    assert_fast_high_R3: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && mag_sq > bands.fast_hi) |=> (corr_q.rate == RATE_FAST && corr_q.down));

    assert_target_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && corr_q.rate != RATE_NONE && corr_q.down &&
         mag_sq >= bands.slow_lo && mag_sq <= bands.target) |=> (corr_q.rate == RATE_NONE));

    assert_invalid_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> $stable(corr_q));
endmodule

// File: rtl/agc_interval_timer.sv
module agc_interval_timer
    import agc_pkg::*;
#(
    parameter int          CNT_W     = 8,
    parameter int unsigned CYC_SETTLE = 4,
    parameter int unsigned CYC_FAST   = 12,
    parameter int unsigned CYC_SLOW   = 20
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  settle,
    input  rate_t rate,
    output logic  tick
);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(CYC_SETTLE - 1);
    localparam logic [CNT_W-1:0] LIM_FAST   = CNT_W'(CYC_FAST - 1);
    localparam logic [CNT_W-1:0] LIM_SLOW   = CNT_W'(CYC_SLOW - 1);

    logic [2:0]       key;
    logic [2:0]       key_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;
    logic             key_same;

    assign key      = {settle, rate};
    assign key_same = (key == key_q);

    always_comb begin
        if (settle)                 lim_m1 = LIM_SETTLE;
        else if (rate == RATE_FAST) lim_m1 = LIM_FAST;
        else                        lim_m1 = LIM_SLOW;
    end

    assign tick = key_same && (rate != RATE_NONE) && (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            key_q <= {1'b0, RATE_NONE};
        end else begin
            key_q <= key;
            if (!key_same || rate == RATE_NONE || tick) cnt <= '0;
            else                                        cnt <= cnt + 1'b1;
        end
    end

    assert_restart_on_change_R9: assert property (@(posedge clk) disable iff (rst)
        !key_same |=> (cnt == '0));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        key_same |-> (cnt <= lim_m1));
endmodule

// File: rtl/agc_gain_stepper.sv
module agc_gain_stepper
    import agc_pkg::*;
#(
    parameter int GAIN_INIT = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  settle,
    input  corr_t corr,
    output gain_t gain
);
    step_t step;

    assign step = step_codes(settle, corr.rate);

    always_ff @(posedge clk) begin
        if (rst)       gain <= gain_t'(GAIN_INIT);
        else if (tick) gain <= apply_step(gain, step, corr.down);
    end

    assert_track_fast_down_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !settle && corr.rate == RATE_FAST && corr.down && gain >= gain_t'(4))
        |=> ({1'b0, gain} + (GAIN_W+1)'(4) == {1'b0, $past(gain)}));

    assert_floor_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && corr.down && gain < gain_t'(step)) |=> (gain == '0));

    assert_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !corr.down && corr.rate != RATE_NONE &&
         {1'b0, gain} + (GAIN_W+1)'(step) > (GAIN_W+1)'(GAIN_MAX)) |=> (gain == gain_t'(GAIN_MAX)));
endmodule

// File: rtl/agc_dual_rate_ctrl.sv
module agc_dual_rate_ctrl
    import agc_pkg::*;
#(
    parameter int CLK_KHZ   = 10000,
    parameter int SETTLE_NS = 3200,
    parameter int FAST_NS   = 819200,
    parameter int SLOW_NS   = 840000000,
    parameter int GAIN_INIT = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_valid,
    input  logic signed [AMP_W-1:0]  sin_amp,
    input  logic signed [AMP_W-1:0]  cos_amp,
    input  logic                     settle_mode,
    input  logic [MAG_W-1:0]         fast_hi_sq,
    input  logic [MAG_W-1:0]         slow_hi_sq,
    input  logic [MAG_W-1:0]         target_sq,
    input  logic [MAG_W-1:0]         slow_lo_sq,
    input  logic [MAG_W-1:0]         fast_lo_sq,
    output logic [GAIN_W-1:0]        gain_code
);
    localparam int unsigned CYC_SETTLE = int'(ns_to_cycles(longint'(CLK_KHZ), longint'(SETTLE_NS)));
    localparam int unsigned CYC_FAST   = int'(ns_to_cycles(longint'(CLK_KHZ), longint'(FAST_NS)));
    localparam int unsigned CYC_SLOW   = int'(ns_to_cycles(longint'(CLK_KHZ), longint'(SLOW_NS)));
    localparam int unsigned CYC_MAX_A  = (CYC_SETTLE > CYC_FAST) ? CYC_SETTLE : CYC_FAST;
    localparam int unsigned CYC_MAX    = (CYC_MAX_A > CYC_SLOW) ? CYC_MAX_A : CYC_SLOW;
    localparam int          CNT_W      = (CYC_MAX > 1) ? $clog2(CYC_MAX) : 1;

    bands_t bands;
    mag_t   mag_sq;
    corr_t  corr;
    logic   tick;
    gain_t  gain;

    assign bands = '{fast_hi: fast_hi_sq, slow_hi: slow_hi_sq, target: target_sq,
                     slow_lo: slow_lo_sq, fast_lo: fast_lo_sq};

    agc_vector_mag u_mag (
        .sin_amp (sin_amp),
        .cos_amp (cos_amp),
        .mag_sq  (mag_sq)
    );

    agc_band_classifier u_class (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .mag_sq       (mag_sq),
        .bands        (bands),
        .corr_q       (corr)
    );

    agc_interval_timer #(
        .CNT_W      (CNT_W),
        .CYC_SETTLE (CYC_SETTLE),
        .CYC_FAST   (CYC_FAST),
        .CYC_SLOW   (CYC_SLOW)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .settle (settle_mode),
        .rate   (corr.rate),
        .tick   (tick)
    );

    agc_gain_stepper #(
        .GAIN_INIT (GAIN_INIT)
    ) u_gain (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .settle (settle_mode),
        .corr   (corr),
        .gain   (gain)
    );

    assign gain_code = gain;

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (corr.rate == RATE_NONE) |=> $stable(gain_code));

    assert_slow_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        (corr.rate == RATE_SLOW) |=>
        (gain_code == $past(gain_code) ||
         {1'b0, gain_code} == {1'b0, $past(gain_code)} + (GAIN_W+1)'(1) ||
         {1'b0, gain_code} + (GAIN_W+1)'(1) == {1'b0, $past(gain_code)}));
endmodule

// File: tb/test_agc_dual_rate_ctrl.sv
module test_agc_dual_rate_ctrl;
    import agc_pkg::*;

    localparam int L_SETTLE = 4;
    localparam int L_FAST   = 12;
    localparam int L_SLOW   = 20;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_valid = 1'b0;
    logic signed [15:0] sin_amp = '0;
    logic signed [15:0] cos_amp = '0;
    logic               settle_mode = 1'b0;
    logic [32:0]        fast_hi_sq = 33'd2250000;
    logic [32:0]        slow_hi_sq = 33'd1210000;
    logic [32:0]        target_sq  = 33'd1000000;
    logic [32:0]        slow_lo_sq = 33'd810000;
    logic [32:0]        fast_lo_sq = 33'd250000;
    logic [6:0]         gain_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    agc_dual_rate_ctrl #(
        .CLK_KHZ   (100000),
        .SETTLE_NS (40),
        .FAST_NS   (120),
        .SLOW_NS   (200),
        .GAIN_INIT (64)
    ) i_agc_dual_rate_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sin_amp      (sin_amp),
        .cos_amp      (cos_amp),
        .settle_mode  (settle_mode),
        .fast_hi_sq   (fast_hi_sq),
        .slow_hi_sq   (slow_hi_sq),
        .target_sq    (target_sq),
        .slow_lo_sq   (slow_lo_sq),
        .fast_lo_sq   (fast_lo_sq),
        .gain_code    (gain_code)
    );

    // Expected code n edges after the band-entry edge: steps at n = 1 + k*L
    function automatic int expect_code(int g0, int n, int l, int step, bit down);
        int g = g0;
        int steps = (n >= 1) ? (n - 1) / l : 0;
        for (int k = 0; k < steps; k++) begin
            g = down ? g - step : g + step;
            if (g < 0)   g = 0;
            if (g > 127) g = 127;
        end
        return g;
    endfunction

    task automatic check(string req, int exp);
        checks++;
        if (int'(gain_code) != exp) begin
            errors++;
            $display("FAIL %s: gain_code=%0d expected=%0d", req, gain_code, exp);
        end
    endtask

    task automatic present(int s, int c);
        sample_valid = 1'b1;
        sin_amp = 16'(s);
        cos_amp = 16'(c);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL R9: watchdog expired, actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        check("R1 reset code", 64);

        // Hold zone with no active correction
        present(1000, 0);
        wait_n(30);
        check("R6 hold zone", 64);

        // Fast-band pair held without valid
        sin_amp = 16'sd1200; cos_amp = 16'sd1200;
        wait_n(40);
        check("R10 no valid ignored", 64);

        // Each component alone is slow band, vector sum is fast band
        present(1200, 1200);
        wait_n(12);
        check("R9 no step before L+1", expect_code(64, 12, L_FAST, 4, 1));
        wait_n(1);
        check("R2 R3 fast down first step", expect_code(64, 13, L_FAST, 4, 1));
        wait_n(18);
        check("R3 fast down second step", expect_code(64, 31, L_FAST, 4, 1));
        present(990, 0);
        wait_n(50);
        check("R7 stop below target", 56);

        // Slow band above, then continuation through hold zone
        present(0, 1200);
        wait_n(20);
        check("R4 slow before step", expect_code(56, 20, L_SLOW, 1, 1));
        wait_n(1);
        check("R4 slow down step", expect_code(56, 21, L_SLOW, 1, 1));
        wait_n(10);
        present(1050, 0);
        wait_n(20);
        check("R7 continue in hold zone", expect_code(56, 52, L_SLOW, 1, 1));
        present(990, 0);
        wait_n(40);
        check("R7 stop after crossing", 54);

        // Fast band below with negative amplitude
        present(-300, 300);
        wait_n(13);
        check("R2 R3 fast up signed", expect_code(54, 13, L_FAST, 4, 0));
        wait_n(18);
        check("R3 fast up repeat", expect_code(54, 31, L_FAST, 4, 0));
        present(1000, 0);
        wait_n(30);
        check("R7 stop at equality", 62);

        // Slow band below
        present(0, -850);
        wait_n(21);
        check("R4 slow up step", expect_code(62, 21, L_SLOW, 1, 0));
        present(1000, 0);
        wait_n(30);
        check("R7 slow up stop", 63);

        // Settle schedule
        settle_mode = 1'b1;
        wait_n(5);
        check("R6 mode switch while idle", 63);
        present(-300, 300);
        wait_n(4);
        check("R9 settle no step yet", expect_code(63, 4, L_SETTLE, 8, 0));
        wait_n(1);
        check("R5 settle fast step 8", expect_code(63, 5, L_SETTLE, 8, 0));
        wait_n(55);
        check("R8 ceiling clamp", expect_code(63, 60, L_SETTLE, 8, 0));
        present(1200, 1200);
        wait_n(100);
        check("R8 floor clamp", 0);

        present(0, -850);
        wait_n(4);
        check("R5 settle slow wait", expect_code(0, 4, L_SETTLE, 1, 0));
        wait_n(1);
        check("R5 settle slow step 1", expect_code(0, 5, L_SETTLE, 1, 0));
        wait_n(38);
        check("R5 settle slow run", expect_code(0, 43, L_SETTLE, 1, 0));

        // Mode switch partway through an interval restarts the counter
        settle_mode = 1'b0;
        wait_n(20);
        check("R9 restart after mode change", 10);
        wait_n(1);
        check("R9 first tracking step", 11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule